// File: doc/BRIEF.md
# Receive Packet Status Queue

This block keeps one 16-bit status word for every packet that sits in a receive buffer, up to eight packets. The receive side marks the start of a frame, each byte that arrives and the end of the frame with its outcome. The host side always sees the status word of the oldest packet. It reads that packet's bytes one at a time, and it drops the packet with a discard command. The payload storage and the frame checking sit outside the block: only lengths and outcomes come in.

The status word has four fields. Bit 15 means "not ready": the head packet is still arriving, or nothing is held. Bits 14..11 hold an error code; bit 14 is the error flag. Bits 10..0 hold the byte count, which is limited to 1514. The block refuses new frames while eight completed packets are held and raises a status-overrun flag. A host read past the bytes received so far sets a sticky underrun flag and signals adapter failure. A receive reset command empties everything.

Top module: `rx_stat_queue`

## Requirements
- R1: After rst_n low or an rx_reset pulse, with no frame in progress, top_status reads 16'h8000: bit 15 set and every other bit zero.
- R2: A completed packet's word is {1'b0, code[3:0], count[10:0]}. rx_complete is high for exactly the one cycle that follows the cycle where frm_end was accepted. The word is visible at the head from that same cycle if no older packet is held.
- R3: frm_err at frm_end maps to bits 14..11 as follows: 0 gives 0000 (no error), 1 overrun 1000, 2 runt 1011, 3 alignment 1100, 4 CRC 1101, 5 dribble 0010, and 6 or 7 give 0000.
- R4: A frame of more than 1514 bytes is stored with code 1001 (oversize), whatever frm_err says, and with count 1514. A frame of exactly 1514 bytes keeps its own code.
- R5: Packets leave in arrival order. discard_top removes the head word and resets the host read offset to zero. discard_top with no completed packet has no effect.
- R6: When no completed packet is held and a frame is in progress, top_status is {1'b1, 4'b0000, bytes received so far}.
- R7: A frm_start that arrives while eight completed packets are held is refused. Its bytes and its frm_end are ignored and give no rx_complete, and status_overrun is set. An effective discard clears status_overrun.
- R8: A host_rd when the read offset already equals the head's count (also when nothing is held) sets rx_underrun and adapter_fail on the next cycle. Reads within the count set nothing. The flags persist through discards until rx_reset or rst_n.
- R9: rx_reset drops every held word, aborts any frame in progress and clears status_overrun, rx_underrun and adapter_fail on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low global reset |
| rx_reset | input | 1 | Receive reset command pulse |
| frm_start | input | 1 | A new frame begins |
| frm_byte | input | 1 | One byte of the current frame arrived |
| frm_end | input | 1 | The current frame is finished |
| frm_err | input | 3 | Frame outcome, sampled with frm_end (R3 encoding) |
| host_rd | input | 1 | Host reads one byte of the head packet |
| discard_top | input | 1 | Remove the head packet's status |
| top_status | output | 16 | Status word of the head packet |
| rx_complete | output | 1 | One-cycle pulse per stored packet |
| status_overrun | output | 1 | A frame was refused because the queue was full |
| rx_underrun | output | 1 | Host read past the received data (sticky) |
| adapter_fail | output | 1 | Adapter failure, raised by the underrun |

## Verification
A wrong write or read pointer shows at the ports as the wrong word at the head. This appears on the first discard after the fault. A wrong occupancy count shows as a frame refused too early or too late: rx_complete is then missing or present against expectation, and status_overrun sets at the wrong frame. A wrong read offset shows as an underrun that comes one read early or late, on the cycle after the faulty read. The bench compares top_status and both flags after every operation, so each of these faults appears within one operation.

// File: rtl/rxq_pkg.sv
// Shared constants and the error-code encoding for the receive status queue.
// Assumes the status word layout {not_ready, code[3:0], count[10:0]}.
package rxq_pkg;
    localparam int unsigned LEN_W   = 11;
    localparam int unsigned WORD_W  = 16;
    localparam int unsigned MAX_LEN = 1514;

    localparam logic [3:0] CODE_NONE    = 4'b0000;
    localparam logic [3:0] CODE_OVERRUN = 4'b1000;
    localparam logic [3:0] CODE_RUNT    = 4'b1011;
    localparam logic [3:0] CODE_ALIGN   = 4'b1100;
    localparam logic [3:0] CODE_CRC     = 4'b1101;
    localparam logic [3:0] CODE_OVERSZ  = 4'b1001;
    localparam logic [3:0] CODE_DRIBBLE = 4'b0010;

    // Map the frame outcome to its 4-bit code; length overflow dominates.
    function automatic logic [3:0] encode_err(input logic [2:0] err, input logic oversize);
        logic [3:0] c;
        case (err)
            3'd1:    c = CODE_OVERRUN;
            3'd2:    c = CODE_RUNT;
            3'd3:    c = CODE_ALIGN;
            3'd4:    c = CODE_CRC;
            3'd5:    c = CODE_DRIBBLE;
            default: c = CODE_NONE;
        endcase
        return oversize ? CODE_OVERSZ : c;
    endfunction
endpackage

// File: rtl/rxq_frame_track.sv
// Follows the frame currently arriving: admits it if the queue has room,
// counts its bytes with saturation just above the length limit, and builds
// the finished status word at frame end.
// Assumes frm_start is not raised while a frame is already in progress.
module rxq_frame_track
    import rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_reset,
    input  logic              frm_start,
    input  logic              frm_byte,
    input  logic              frm_end,
    input  logic [2:0]        frm_err,
    input  logic              full,
    output logic              active,
    output logic [LEN_W-1:0]  live_len,
    output logic              start_refused,
    output logic              done,
    output logic [WORD_W-1:0] done_word
);
    localparam logic [LEN_W-1:0] CAP  = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0] SATV = LEN_W'(MAX_LEN + 1);

    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] cnt_nxt;
    logic             oversize;

    // Byte count including a byte arriving this cycle, held at limit+1.
    always_comb begin
        cnt_nxt = cnt;
        if (frm_byte && cnt < SATV)
            cnt_nxt = cnt + LEN_W'(1);
    end

    // Frame-end word and the visible running count.
    always_comb begin
        done          = active && frm_end;
        start_refused = frm_start && !active && full;
        oversize      = cnt_nxt > CAP;
        done_word     = {1'b0, encode_err(frm_err, oversize), (oversize ? CAP : cnt_nxt)};
        live_len      = (cnt > CAP) ? CAP : cnt;
    end

    // Frame admission and byte counting.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_reset) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (done) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (frm_start && !active && !full) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            cnt <= cnt_nxt;
        end
    end

    a_r7_admit_only_with_room: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(!full));
    a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> cnt <= SATV);
endmodule

// File: rtl/rxq_stat_fifo.sv
// Circular store of finished status words, oldest at the head.
// Assumes the writer never pushes while full unless a pop happens too.
module rxq_stat_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] push_word,
    input  logic         pop,
    output logic [W-1:0] head_word,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic         full,
    output logic         nonempty
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_eff, pop_eff;

    // Occupancy flags and effective push/pop.
    always_comb begin
        full      = level == CNT_W'(DEPTH);
        nonempty  = level != '0;
        pop_eff   = pop && nonempty;
        push_eff  = push && (!full || pop_eff);
        head_word = mem[rd_ptr];
    end

    // Word storage, written at the write pointer.
    always_ff @(posedge clk) begin
        if (push_eff)
            mem[wr_ptr] <= push_word;
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_eff) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
            if (pop_eff)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
            case ({push_eff, pop_eff})
                2'b10:   level <= level + CNT_W'(1);
                2'b01:   level <= level - CNT_W'(1);
                default: level <= level;
            endcase
        end
    end

    a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH));
    a_r5_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && nonempty && !push && !clr) |=> level == $past(level) - CNT_W'(1));
endmodule

// File: rtl/rxq_host_port.sv
// Host read offset within the head packet and the sticky underrun flag.
// Assumes top_len is the byte count the head currently offers (0 if none).
module rxq_host_port
    import rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_reset,
    input  logic             host_rd,
    input  logic             pop_eff,
    input  logic [LEN_W-1:0] top_len,
    output logic             underrun
);
    logic [LEN_W-1:0] rd_off;
    logic             avail;

    // A byte remains when the offset is short of the head's count.
    always_comb avail = rd_off < top_len;

    // Offset advance, reset on discard, and underrun latching.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_reset) begin
            rd_off   <= '0;
            underrun <= 1'b0;
        end else begin
            if (pop_eff)
                rd_off <= '0;
            else if (host_rd && avail)
                rd_off <= rd_off + LEN_W'(1);
            if (host_rd && !pop_eff && !avail)
                underrun <= 1'b1;
        end
    end

    a_r8_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !rx_reset) |=> underrun);
    a_r8_underrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(host_rd));
endmodule

// File: rtl/rx_stat_queue.sv
// Receive packet status queue top: joins the frame tracker, the status word
// store and the host port, presents the head word and keeps the overrun flag.
// Assumes single-clock operation and sync reset commands.
module rx_stat_queue
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_reset,
    input  logic        frm_start,
    input  logic        frm_byte,
    input  logic        frm_end,
    input  logic [2:0]  frm_err,
    input  logic        host_rd,
    input  logic        discard_top,
    output logic [15:0] top_status,
    output logic        rx_complete,
    output logic        status_overrun,
    output logic        rx_underrun,
    output logic        adapter_fail
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic              active, start_refused, done, full, nonempty, pop_eff;
    logic [LEN_W-1:0]  live_len;
    logic [WORD_W-1:0] done_word, head_word;
    logic [CNT_W-1:0]  level;

    rxq_frame_track u_track (
        .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset),
        .frm_start(frm_start), .frm_byte(frm_byte), .frm_end(frm_end),
        .frm_err(frm_err), .full(full), .active(active), .live_len(live_len),
        .start_refused(start_refused), .done(done), .done_word(done_word)
    );

    rxq_stat_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(rx_reset), .push(done),
        .push_word(done_word), .pop(discard_top), .head_word(head_word),
        .level(level), .full(full), .nonempty(nonempty)
    );

    // Discard only acts when a finished packet is held.
    always_comb pop_eff = discard_top && nonempty;

    // Head word: finished packet, else in-progress frame, else empty marker.
    always_comb begin
        if (nonempty)
            top_status = head_word;
        else if (active)
            top_status = {1'b1, 4'b0000, live_len};
        else
            top_status = 16'h8000;
    end

    rxq_host_port u_host (
        .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset), .host_rd(host_rd),
        .pop_eff(pop_eff), .top_len(top_status[LEN_W-1:0]), .underrun(rx_underrun)
    );

    always_comb adapter_fail = rx_underrun;

    // Completion pulse and refusal flag.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_reset) begin
            rx_complete    <= 1'b0;
            status_overrun <= 1'b0;
        end else begin
            rx_complete <= done;
            if (pop_eff)
                status_overrun <= 1'b0;
            else if (start_refused)
                status_overrun <= 1'b1;
        end
    end

    a_r2_pulse_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        rx_complete |-> $past(frm_end));
    a_r7_overrun_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_overrun) |-> $past(discard_top || rx_reset));
    a_r9_reset_empties: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reset |=> (top_status == 16'h8000 && !status_overrun && !rx_underrun));
    a_r1_level_vs_status: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && !active) |-> top_status[15]);
endmodule

// File: tb/tb_rx_stat_queue.sv
module tb_rx_stat_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_reset = 1'b0, frm_start = 1'b0, frm_byte = 1'b0, frm_end = 1'b0;
    logic [2:0]  frm_err = 3'd0;
    logic        host_rd = 1'b0, discard_top = 1'b0;
    logic [15:0] top_status;
    logic        rx_complete, status_overrun, rx_underrun, adapter_fail;

    always #10 clk = ~clk;

    rx_stat_queue dut (.*);

    int n_chk = 0, n_fail = 0;
    logic [15:0] mq[$];
    bit  m_act = 0, m_ovf = 0, m_und = 0;
    int  m_cnt = 0, m_off = 0;

    function automatic logic [15:0] enc(input int len, input int err);
        logic [3:0] c;
        case (err)
            1: c = 4'b1000; 2: c = 4'b1011; 3: c = 4'b1100;
            4: c = 4'b1101; 5: c = 4'b0010; default: c = 4'b0000;
        endcase
        if (len > 1514) begin c = 4'b1001; len = 1514; end
        return {1'b0, c, 11'(len)};
    endfunction

    function automatic logic [15:0] exp_top();
        if (mq.size() > 0) return mq[0];
        if (m_act) return {5'b10000, 11'((m_cnt > 1514) ? 1514 : m_cnt)};
        return 16'h8000;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic check_state(input string req);
        chk(req, 32'(top_status), 32'(exp_top()));
        chk({req, " overrun"}, 32'(status_overrun), 32'(m_ovf));
        chk({req, " underrun"}, 32'(rx_underrun), 32'(m_und));
        chk({req, " adapter_fail"}, 32'(adapter_fail), 32'(m_und));
    endtask

    task automatic send_frame(input int len, input int err, input bit peek);
        bit acc;
        frm_start = 1; tick(); frm_start = 0;
        acc = (mq.size() < 8);
        if (acc) begin m_act = 1; m_cnt = 0; end else m_ovf = 1;
        for (int i = 0; i < len; i++) begin
            frm_byte = 1; tick(); frm_byte = 0;
            if (acc) m_cnt++;
            if (peek && i == len / 2) check_state("R6 in-progress head");
        end
        frm_end = 1; frm_err = 3'(err); tick(); frm_end = 0; frm_err = 0;
        chk("R2 rx_complete pulse", 32'(rx_complete), 32'(acc));
        if (acc) begin mq.push_back(enc(len, err)); m_act = 0; m_cnt = 0; end
        check_state(acc ? "R2 R3 stored word" : "R7 refused frame");
        tick();
        chk("R2 pulse is one cycle", 32'(rx_complete), 0);
    endtask

    task automatic host_read(input int n);
        for (int i = 0; i < n; i++) begin
            int tl;
            tl = exp_top()[10:0];
            host_rd = 1; tick(); host_rd = 0;
            if (m_off < tl) m_off++; else m_und = 1;
        end
        check_state("R8 host reads");
    endtask

    task automatic discard();
        discard_top = 1; tick(); discard_top = 0;
        if (mq.size() > 0) begin void'(mq.pop_front()); m_off = 0; m_ovf = 0; end
        check_state("R5 discard");
    endtask

    task automatic do_rx_reset();
        rx_reset = 1; tick(); rx_reset = 0;
        mq.delete(); m_act = 0; m_cnt = 0; m_off = 0; m_ovf = 0; m_und = 0;
        check_state("R9 rx_reset");
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        repeat (3) tick();
        rst_n = 1; tick();
        check_state("R1 reset state");
        discard();                              // R5: discard on empty ignored
        send_frame(0, 0, 0);                    // R2: zero-length packet
        send_frame(12, 4, 1);                   // R3 CRC, R6 peek is behind head
        discard(); discard();
        for (int e = 0; e < 8; e++) begin       // R3: every outcome code
            send_frame(5 + e, e, 1);
            discard();
        end
        send_frame(1514, 2, 0);                 // R4: exactly at limit
        send_frame(1600, 4, 0);                 // R4: oversize, count capped
        discard();
        chk("R4 oversize word", 32'(top_status), 32'(enc(1600, 4)));
        host_read(1514);                        // R8: full read allowed
        discard();
        for (int i = 0; i < 9; i++) send_frame(3 + i, 0, 0);  // R7: ninth refused
        chk("R7 overrun set", 32'(status_overrun), 1);
        for (int i = 0; i < 3; i++) discard();  // R5 order, R7 clear
        do_rx_reset();
        // Random phase.
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 4) send_frame($urandom_range(0, 40), $urandom_range(0, 7), 1);
            else if (op < 7) begin
                int av;
                av = exp_top()[10:0] - m_off;
                host_read((av > 0) ? $urandom_range(1, av) : 0);
            end else discard();
        end
        // R8 directed: read past end, sticky through discard and new frames.
        while (mq.size() > 0) discard();
        send_frame(2, 1, 0);
        host_read(3);
        chk("R8 underrun raised", 32'(rx_underrun), 1);
        discard();
        send_frame(4, 0, 0);
        chk("R8 underrun sticky", 32'(adapter_fail), 1);
        frm_start = 1; tick(); frm_start = 0; m_act = 1; m_cnt = 0;
        do_rx_reset();                          // R9 aborts frame in progress
        chk("R9 flags cleared", 32'({rx_underrun, status_overrun}), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule